// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This controller decides which clock enables of a small microcontroller stay on when the core goes to sleep. Software first selects one of three low-power levels through a 2-bit mode field and arms a sleep-enable bit. A one-cycle sleep command then moves the controller from running into the chosen level, and it gates the CPU, flash, I/O, ADC and oscillator enables to match. A fourth code is reserved and has no effect.

While asleep, the controller watches a 12-bit vector of wake requests. Each level admits its own subset: the lightest level accepts every source, the deepest accepts only the asynchronous ones. When an admitted request appears, the two lighter levels restore every clock on the next cycle. The deepest level first restarts the oscillator and holds the other clocks off for a start-up window whose length is chosen by a 2-bit configuration code. On entry to either lighter level with the ADC enabled, the controller issues a one-cycle conversion-start pulse.

Top module: `slp_ctrl`

## Requirements
- R1: After reset every clock enable and `osc_run` is 1, `asleep` is 0 and `adc_kick` is 0.
- R2: A `sleep_cmd` pulse in the running state is honoured only when `sleep_en` is 1; the enables change on the cycle after the command is sampled, and with `sleep_en` 0 nothing changes.
- R3: Mode code 2'b00 (light) turns off the CPU and flash enables and keeps I/O, ADC and oscillator on.
- R4: Mode code 2'b01 (quiet-ADC) turns off the CPU, flash and I/O enables and keeps ADC and oscillator on.
- R5: Mode code 2'b10 (deep) turns off all four clock enables and `osc_run`.
- R6: Mode code 2'b11 is reserved: a sleep command carrying it is ignored and the controller stays running.
- R7: Entering mode 00 or 01 with `adc_en` 1 produces exactly one cycle of `adc_kick`, in the first sleeping cycle; deep mode or `adc_en` 0 produces none.
- R8: Wake bit positions are: 0 external reset, 1 watchdog reset, 2 brown-out, 3 serial start, 4 external level interrupt, 5 pin change, 6 EEPROM ready, 7 ADC done, 8 external edge interrupt, 9 timer overflow, 10 serial overflow, 11 comparator. Mode 00 accepts bits 0-11, mode 01 bits 0-7, mode 10 bits 0-5; any other request leaves the controller asleep.
- R9: From mode 00 or 01, an accepted wake request restores all enables on the cycle after it is sampled.
- R10: From mode 10, an accepted wake request starts a window of `4 << (2*startup_sel)` cycles (sampled at wake) in which only `osc_run` is 1; all enables return together on the following cycle.
- R11: Wake requests while running have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_en | input | 1 | Arms the sleep command |
| sleep_cmd | input | 1 | One-cycle request to enter sleep |
| sleep_mode | input | 2 | Low-power level select |
| adc_en | input | 1 | ADC is enabled |
| startup_sel | input | 2 | Start-up window select for deep wake |
| wake_src | input | 12 | Wake requests, bit map in R8 |
| ck_cpu_en | output | 1 | CPU clock enable |
| ck_flash_en | output | 1 | Flash clock enable |
| ck_io_en | output | 1 | I/O clock enable |
| ck_adc_en | output | 1 | ADC clock enable |
| osc_run | output | 1 | Oscillator run enable |
| adc_kick | output | 1 | Conversion-start pulse |
| asleep | output | 1 | Controller is not in the running state |

## Verification
The bench targets wake requests outside the current mode's mask, such as ADC done or timer overflow in deep mode; a design with a wrong mask would wake early and show running enables. It checks the reserved code and a cleared sleep-enable, where a careless decoder would gate clocks. It measures the deep start-up window at both edges for every select value, so an off-by-one counter shows up as clocks returning one cycle early or late, and it confirms the ADC pulse lasts exactly one cycle and never appears in deep mode.

// File: rtl/slp_pkg.sv
// Shared types and constants for the sleep controller.
// Assumes a 12-bit wake vector with the fixed bit map of the brief.
package slp_pkg;

    localparam int WAKE_W = 12;

    typedef enum logic [1:0] {
        MD_LIGHT = 2'b00,
        MD_QADC  = 2'b01,
        MD_DEEP  = 2'b10,
        MD_RSVD  = 2'b11
    } sleep_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_START = 2'b10
    } ctl_state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic osc;
    } clk_en_t;

    // Accepted wake sources per mode
    localparam logic [WAKE_W-1:0] MASK_LIGHT = 12'hFFF;
    localparam logic [WAKE_W-1:0] MASK_QADC  = 12'h0FF;
    localparam logic [WAKE_W-1:0] MASK_DEEP  = 12'h03F;

endpackage

// File: rtl/slp_wake_filter.sv
// Reduces the wake request vector to one hit bit, using the mask of the
// latched sleep mode. Assumes requests are already synchronous to clk.
module slp_wake_filter
    import slp_pkg::*;
#(
    parameter int N_WAKE = WAKE_W
) (
    input  logic [1:0]        mode,
    input  logic [N_WAKE-1:0] wake,
    output logic              hit
);

    logic [N_WAKE-1:0] mask;

    // Select the accepted-source mask for the mode
    always_comb begin
        unique case (sleep_mode_e'(mode))
            MD_LIGHT: mask = MASK_LIGHT;
            MD_QADC:  mask = MASK_QADC;
            MD_DEEP:  mask = MASK_DEEP;
            default:  mask = '0;
        endcase
    end

    // Any accepted request ends sleep
    always_comb hit = |(wake & mask);

endmodule

// File: rtl/slp_startup_timer.sv
// Down-counter for the deep-mode start-up window. A load sets the count to
// (BASE_DLY << 2*sel) - 1; done is high while the count is zero.
module slp_startup_timer #(
    parameter int BASE_DLY = 4,
    localparam int MAX_DLY = BASE_DLY << 6,
    localparam int CNT_W   = $clog2(MAX_DLY) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       done
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    // Terminal count from the select code
    always_comb term = CNT_W'((BASE_DLY << (2 * sel)) - 1);

    // Load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= term;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    always_comb done = (cnt == '0);

    a_r10_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(term));

    a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/slp_clk_gate.sv
// Maps controller state and latched mode to the five clock enables.
// Assumes the state register is the only source of gating decisions.
module slp_clk_gate
    import slp_pkg::*;
(
    input  logic [1:0] state,
    input  logic [1:0] mode,
    output clk_en_t    en
);

    // Enable set per state and mode
    always_comb begin
        en = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
        unique case (ctl_state_e'(state))
            ST_SLEEP: begin
                unique case (sleep_mode_e'(mode))
                    MD_LIGHT: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
                    MD_QADC:  en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
                    default:  en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
                endcase
            end
            ST_START: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
            default:  ;
        endcase
    end

    a_r5_osc_gates_all: assert final (en.osc || !(en.cpu || en.flash || en.io || en.adc));

endmodule

// File: rtl/slp_ctrl.sv
// Sleep mode clock gating controller. Enters a low-power level on an armed
// sleep command, gates clock enables per level, wakes on accepted sources
// and inserts a start-up window when leaving deep mode.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int N_WAKE   = WAKE_W,
    parameter int BASE_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_en,
    input  logic              sleep_cmd,
    input  logic [1:0]        sleep_mode,
    input  logic              adc_en,
    input  logic [1:0]        startup_sel,
    input  logic [N_WAKE-1:0] wake_src,
    output logic              ck_cpu_en,
    output logic              ck_flash_en,
    output logic              ck_io_en,
    output logic              ck_adc_en,
    output logic              osc_run,
    output logic              adc_kick,
    output logic              asleep
);

    ctl_state_e state;
    logic [1:0] cur_mode;
    logic       wake_hit;
    logic       tmr_load;
    logic       tmr_done;
    logic       enter;
    clk_en_t    en;

    slp_wake_filter #(.N_WAKE(N_WAKE)) u_filter (
        .mode (cur_mode),
        .wake (wake_src),
        .hit  (wake_hit)
    );

    slp_startup_timer #(.BASE_DLY(BASE_DLY)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .sel   (startup_sel),
        .done  (tmr_done)
    );

    slp_clk_gate u_gate (
        .state (state),
        .mode  (cur_mode),
        .en    (en)
    );

    // Armed, non-reserved sleep request while running
    always_comb enter = (state == ST_RUN) && sleep_cmd && sleep_en
                        && (sleep_mode != MD_RSVD);

    // Start the window when deep sleep sees an accepted wake
    always_comb tmr_load = (state == ST_SLEEP) && wake_hit && (cur_mode == MD_DEEP);

    // Controller state machine and mode latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            cur_mode <= MD_LIGHT;
        end else begin
            unique case (state)
                ST_RUN: if (enter) begin
                    state    <= ST_SLEEP;
                    cur_mode <= sleep_mode;
                end
                ST_SLEEP: if (wake_hit)
                    state <= (cur_mode == MD_DEEP) ? ST_START : ST_RUN;
                ST_START: if (tmr_done) state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end

    // One-cycle conversion start on entry to the lighter levels
    always_ff @(posedge clk) begin
        if (!rst_n) adc_kick <= 1'b0;
        else        adc_kick <= enter && adc_en && (sleep_mode != MD_DEEP);
    end

    always_comb begin
        ck_cpu_en   = en.cpu;
        ck_flash_en = en.flash;
        ck_io_en    = en.io;
        ck_adc_en   = en.adc;
        osc_run     = en.osc;
        asleep      = (state != ST_RUN);
    end

    a_r6_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_cmd && sleep_mode == MD_RSVD) |=> !asleep);

    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_cmd && !sleep_en) |=> !asleep);

    a_r7_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_kick |=> !adc_kick);

    a_r7_kick_light_only: assert property (@(posedge clk) disable iff (!rst_n)
        adc_kick |-> (asleep && !ck_cpu_en && osc_run));

    a_r10_deep_via_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && cur_mode == MD_DEEP) |=> state != ST_RUN);

    a_r10_start_osc_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> (osc_run && !ck_cpu_en && !ck_adc_en));

endmodule

// File: tb/slp_ctrl_bench.sv
`timescale 1ns/1ps
module slp_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sleep_en, sleep_cmd, adc_en;
    logic [1:0]  sleep_mode, startup_sel;
    logic [11:0] wake_src;
    logic ck_cpu_en, ck_flash_en, ck_io_en, ck_adc_en, osc_run, adc_kick, asleep;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    slp_ctrl u_slp_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_cmd(sleep_cmd),
        .sleep_mode(sleep_mode), .adc_en(adc_en), .startup_sel(startup_sel),
        .wake_src(wake_src), .ck_cpu_en(ck_cpu_en), .ck_flash_en(ck_flash_en),
        .ck_io_en(ck_io_en), .ck_adc_en(ck_adc_en), .osc_run(osc_run),
        .adc_kick(adc_kick), .asleep(asleep)
    );

    // {cpu, flash, io, adc, osc, asleep}
    localparam logic [5:0] P_RUN   = 6'b111110;
    localparam logic [5:0] P_START = 6'b000011;

    function automatic logic [5:0] pat_sleep(input logic [1:0] m);
        case (m)
            2'b00:   return 6'b001111;
            2'b01:   return 6'b000111;
            default: return 6'b000001;
        endcase
    endfunction

    function automatic logic [11:0] accept_mask(input logic [1:0] m);
        case (m)
            2'b00:   return 12'hFFF;
            2'b01:   return 12'h0FF;
            default: return 12'h03F;
        endcase
    endfunction

    function automatic logic [5:0] outs();
        return {ck_cpu_en, ck_flash_en, ck_io_en, ck_adc_en, osc_run, asleep};
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [1:0] m, input logic en, input logic adc,
                           input logic [1:0] sel, input int bitpos);
        logic takes;
        logic [11:0] w;
        int dly;
        takes = en && (m != 2'b11);
        @(negedge clk);
        sleep_mode = m; sleep_en = en; adc_en = adc; startup_sel = sel; sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        check(outs(), takes ? pat_sleep(m) : P_RUN, "R2/R3/R4/R5/R6 entry");
        check({5'b0, adc_kick}, {5'b0, takes && adc && (m != 2'b10)}, "R7 kick");
        @(negedge clk);
        check({5'b0, adc_kick}, 6'b0, "R7 kick width");
        if (!takes) return;
        w = 12'b1 << bitpos;
        wake_src = w;
        @(negedge clk);
        wake_src = '0;
        if ((w & accept_mask(m)) == '0) begin
            check(outs(), pat_sleep(m), "R8 rejected wake");
            wake_src = 12'h001;
            @(negedge clk);
            wake_src = '0;
        end
        if (m != 2'b10) begin
            check(outs(), P_RUN, "R9 wake light");
        end else begin
            dly = 4 << (2 * sel);
            check(outs(), P_START, "R10 window start");
            repeat (dly - 1) @(negedge clk);
            check(outs(), P_START, "R10 window end");
            @(negedge clk);
            check(outs(), P_RUN, "R10 release");
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; sleep_en = 0; sleep_cmd = 0; adc_en = 0;
        sleep_mode = 0; startup_sel = 0; wake_src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(outs(), P_RUN, "R1 reset enables");
        check({5'b0, adc_kick}, 6'b0, "R1 reset kick");

        // R11: wakes while running have no effect
        wake_src = 12'hFFF;
        @(negedge clk);
        wake_src = '0;
        check(outs(), P_RUN, "R11 wake while running");

        // Directed corners
        run_one(2'b00, 1, 1, 0, 11);   // R3 with comparator wake
        run_one(2'b01, 1, 1, 0, 9);    // R4, timer overflow rejected
        run_one(2'b01, 1, 0, 0, 7);    // R4, ADC done accepted, no kick
        run_one(2'b10, 1, 1, 0, 7);    // R5, ADC done rejected, no kick
        run_one(2'b10, 1, 0, 3, 6);    // R10 longest window, EEPROM rejected
        run_one(2'b10, 1, 0, 1, 5);    // R10 pin change accepted
        run_one(2'b11, 1, 1, 0, 0);    // R6 reserved
        run_one(2'b00, 0, 1, 0, 0);    // R2 not armed

        // Random mix
        for (int i = 0; i < 40; i++) begin
            run_one(2'($urandom % 4), 1'($urandom % 4 != 0), 1'($urandom % 2),
                    2'($urandom % 4), int'($urandom % 12));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule